// File: doc/BRIEF.md
# Configurable SPI shift engine

This block is the serial core of an SPI port that works as either the clock-owning master or a clocked slave. It exchanges one byte in both directions at once over the MOSI, MISO and SCK lines, most significant bit first. Clock polarity and clock phase are selectable. A neighbouring register block drives its configuration and feeds it bytes through a load strobe. It receives each completed byte together with a one-cycle done pulse.

As master, the engine makes SCK from the system clock with one of four fixed divisors. It also watches its slave-select input for another master pulling it low, and reports that as a mode fault. As slave, it follows an external SCK gated by an active-low slave-select. SCK, MOSI and slave-select are first passed through two-flop synchronizers, so the fastest usable slave clock is a fraction of the system clock. The pad drivers are modelled as a value and an output-enable per line. An optional open-drain mode makes the pins drive only low.

Top module: `spi_xfer_core`

## Requirements
- R1: In master mode, a load strobe while idle starts one transfer. It sends `tx_byte` on `mosi_out` most significant bit first, and it assembles the 8 bits sampled on `miso_in` (first sample lands in bit 7) into `rx_byte`.
- R2: In master mode, SCK toggles every H system cycles. H is 1, 4, 16 or 64 for `rate` = 0, 1, 2 or 3, giving SCK periods of 2, 8, 32 and 128 system cycles. In slave mode, `rate` has no effect on the result.
- R3: While the master is idle, `sck_out` equals `cpol`. After the 16th toggle of a transfer, it is back at `cpol`.
- R4: Every transfer has exactly 16 SCK edges. With `cpha`=0, data is sampled on edges 1,3,..,15 and the outgoing bit changes on edges 2,4,..,14. With `cpha`=1, the outgoing bit changes on edges 3,5,..,15 and data is sampled on edges 2,4,..,16.
- R5: In slave mode, the byte loaded while between bytes is shifted out on `miso_out`, and the byte clocked in on `mosi_in` is delivered on `rx_byte`. The slave begins only after it has seen `ss_n` high. With `cpha`=1, consecutive bytes may follow with `ss_n` held low.
- R6: In slave mode with `cpha`=0, after a byte completes, further SCK edges are ignored until `ss_n` has gone high and low again. No done pulse follows them.
- R7: In master mode with `en`=1, a low `ss_n` raises `mode_fault` within 3 cycles. This aborts any transfer without a done pulse, releases `sck_oe` and `mosi_oe`, and makes the block ignore load strobes. When `ss_n` returns high, `mode_fault` clears.
- R8: With `wired_or`=1, each of the three line outputs presents 0 on its `*_out` port. Its `*_oe` is high only while the line should be low. With `wired_or`=0, the line drives its level whenever enabled.
- R9: With `en`=0, load strobes are ignored, no done pulse occurs, and all three output enables are low.
- R10: `done` is high for exactly one system cycle per completed byte. `rx_byte` keeps the received byte until the next byte completes, and reads 0 after reset.
- R11: With `cpha`=0, the first data bit is on `mosi_out` in the cycle after the load strobe (master). As a slave, it is on `miso_out` once `ss_n` is low, before the first SCK edge.
- R12: In slave mode, `miso_oe` is low while `ss_n` is high and high while `ss_n` is low (push-pull).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| master | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase select |
| rate | input | 2 | Master SCK divisor select |
| wired_or | input | 1 | Open-drain line outputs |
| ld | input | 1 | Load strobe for tx_byte |
| tx_byte | input | 8 | Byte to send |
| done | output | 1 | One-cycle byte-complete pulse |
| rx_byte | output | 8 | Last received byte |
| mode_fault | output | 1 | Master slave-select pulled low |
| sck_in | input | 1 | SCK line as seen at the pin |
| sck_out | output | 1 | SCK drive value |
| sck_oe | output | 1 | SCK drive enable |
| mosi_in | input | 1 | MOSI line as seen at the pin |
| mosi_out | output | 1 | MOSI drive value |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_in | input | 1 | MISO line as seen at the pin |
| miso_out | output | 1 | MISO drive value |
| miso_oe | output | 1 | MISO drive enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
The assertions assume that `cpol`, `cpha`, `rate` and `master` do not change while a byte is in flight. They also assume that successive slave SCK edges are several system cycles apart, so the synchronizers see every edge. The bench changes configuration only while the engine is idle and between bytes. It clocks the slave with eight system cycles per SCK half period, which keeps it well inside that limit.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int RATE_W   = 2;
  localparam int DIV_W    = 7;
  localparam int NUM_PADS = 3;
  localparam int PAD_SCK  = 0;
  localparam int PAD_MOSI = 1;
  localparam int PAD_MISO = 2;

  // half SCK period in system cycles: 4**rate
  function automatic logic [DIV_W-1:0] half_period(input logic [RATE_W-1:0] r);
    return DIV_W'(1) << (2 * r);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half;

  always_comb begin
    half = half_period(rate);
    tick = run && (cnt_q == half - 1'b1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_period(rate)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          edge_stb,
  input  logic          cpha,
  input  logic          rx_bit,
  output logic          tx_msb,
  output logic [DW-1:0] rx_word,
  output logic          last_edge,
  output logic          idle
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          sample_edge;
  logic          shift_edge;

  always_comb begin
    sample_edge = edge_stb && (cnt_q[0] == cpha);
    shift_edge  = edge_stb && (cnt_q[0] != cpha) && !(cpha && cnt_q == '0);
    last_edge   = edge_stb && (cnt_q == CW'(EDGES - 1));

    if (clear)          cnt_d = '0;
    else if (last_edge) cnt_d = '0;
    else if (edge_stb)  cnt_d = cnt_q + 1'b1;
    else                cnt_d = cnt_q;

    if (load)            tx_d = load_data;
    else if (shift_edge) tx_d = {tx_q[DW-2:0], 1'b0};
    else                 tx_d = tx_q;

    if (sample_edge) rx_d = {rx_q[DW-2:0], rx_bit};
    else             rx_d = rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  assign tx_msb  = tx_q[DW-1];
  assign rx_word = rx_d;
  assign idle    = (cnt_q == '0);
endmodule

// File: rtl/spi_pad.sv
module spi_pad (
  input  logic drive,
  input  logic wired,
  input  logic value,
  output logic pin_out,
  output logic pin_oe
);
  assign pin_out = wired ? 1'b0 : value;
  assign pin_oe  = drive && (!wired || !value);
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core
  import spi_xfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [RATE_W-1:0] rate,
  input  logic              wired_or,
  input  logic              ld,
  input  logic [DW-1:0]     tx_byte,
  output logic              done,
  output logic [DW-1:0]     rx_byte,
  output logic              mode_fault,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rstn_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rstn_i     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rstn_i     <= rst_meta_q;
    end
  end

  // input synchronizers: {ss, sck, mosi}
  logic [2:0] sync_q;
  logic       ss_s, sck_s, mosi_s;
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rstn_i),
    .d     ({ss_n, sck_in, mosi_in}),
    .q     (sync_q)
  );
  assign ss_s   = sync_q[2];
  assign sck_s  = sync_q[1];
  assign mosi_s = sync_q[0];

  // state
  logic          m_run_q, m_run_d;
  logic          sck_lvl_q, sck_lvl_d;
  logic          armed_q, armed_d;
  logic          sck_prev_q;
  logic          done_q, done_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          fault_q;

  // combinational control
  logic          fault, slave_on, tick, m_edge, s_edge, edge_stb;
  logic          m_start, s_load, sh_load, sh_clear, rx_bit;
  logic          tx_msb, last_edge, sh_idle;
  logic [DW-1:0] rx_word;

  spi_rate_gen u_rate (
    .clk   (clk),
    .rst_n (rstn_i),
    .run   (m_run_q),
    .rate  (rate),
    .tick  (tick)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rstn_i),
    .clear     (sh_clear),
    .load      (sh_load),
    .load_data (tx_byte),
    .edge_stb  (edge_stb),
    .cpha      (cpha),
    .rx_bit    (rx_bit),
    .tx_msb    (tx_msb),
    .rx_word   (rx_word),
    .last_edge (last_edge),
    .idle      (sh_idle)
  );

  always_comb begin
    fault    = en && master && !ss_s;
    slave_on = en && !master;
    m_edge   = m_run_q && tick;
    s_edge   = slave_on && !ss_s && armed_q && (sck_s != sck_prev_q);
    edge_stb = master ? m_edge : s_edge;
    rx_bit   = master ? miso_in : mosi_s;
    m_start  = en && master && !fault && ld && !m_run_q;
    s_load   = slave_on && ld && sh_idle;
    sh_load  = m_start || s_load;
    sh_clear = !en || (master ? fault : ss_s);

    if (!en || !master || fault) m_run_d = 1'b0;
    else if (m_start)            m_run_d = 1'b1;
    else if (last_edge)          m_run_d = 1'b0;
    else                         m_run_d = m_run_q;

    if (m_edge)        sck_lvl_d = !sck_lvl_q;
    else if (!m_run_q) sck_lvl_d = cpol;
    else               sck_lvl_d = sck_lvl_q;

    if (!slave_on)               armed_d = 1'b0;
    else if (ss_s)               armed_d = 1'b1;
    else if (last_edge && !cpha) armed_d = 1'b0;
    else                         armed_d = armed_q;

    done_d = en && last_edge;
    rx_d   = last_edge ? rx_word : rx_q;
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      m_run_q    <= 1'b0;
      sck_lvl_q  <= 1'b0;
      armed_q    <= 1'b0;
      sck_prev_q <= 1'b0;
      done_q     <= 1'b0;
      rx_q       <= '0;
      fault_q    <= 1'b0;
    end else begin
      m_run_q    <= m_run_d;
      sck_lvl_q  <= sck_lvl_d;
      armed_q    <= armed_d;
      sck_prev_q <= sck_s;
      done_q     <= done_d;
      rx_q       <= rx_d;
      fault_q    <= fault;
    end
  end

  // line drivers
  logic [NUM_PADS-1:0] pad_drv, pad_val, pad_out, pad_oe;
  always_comb begin
    pad_drv[PAD_SCK]  = en && master && !fault;
    pad_val[PAD_SCK]  = sck_lvl_q;
    pad_drv[PAD_MOSI] = en && master && !fault;
    pad_val[PAD_MOSI] = tx_msb;
    pad_drv[PAD_MISO] = slave_on && !ss_s;
    pad_val[PAD_MISO] = tx_msb;
  end

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    spi_pad u_pad (
      .drive   (pad_drv[g]),
      .wired   (wired_or),
      .value   (pad_val[g]),
      .pin_out (pad_out[g]),
      .pin_oe  (pad_oe[g])
    );
  end

  assign sck_out    = pad_out[PAD_SCK];
  assign sck_oe     = pad_oe[PAD_SCK];
  assign mosi_out   = pad_out[PAD_MOSI];
  assign mosi_oe    = pad_oe[PAD_MOSI];
  assign miso_out   = pad_out[PAD_MISO];
  assign miso_oe    = pad_oe[PAD_MISO];
  assign done       = done_q;
  assign rx_byte    = rx_q;
  assign mode_fault = fault_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    done_q |=> !done_q);
  // R3
  idle_return_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    (done_q && master) |-> (sck_lvl_q == cpol));
  // R7
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    fault_q |-> !m_run_q);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstn_i)
    !en |=> (!done_q && !m_run_q));
endmodule

// File: tb/spi_xfer_core_bench.sv
`timescale 1ns/1ps
module spi_xfer_core_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 150000;
  localparam int  SH         = 8;

  logic       clk, rst_n, en, master, cpol, cpha, wired_or, ld;
  logic [1:0] rate;
  logic [7:0] tx_byte, rx_byte;
  logic       done, mode_fault;
  logic       sck_in, sck_out, sck_oe, mosi_in, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe, ss_n;

  spi_xfer_core u_spi_xfer_core (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
    .cpha(cpha), .rate(rate), .wired_or(wired_or), .ld(ld),
    .tx_byte(tx_byte), .done(done), .rx_byte(rx_byte),
    .mode_fault(mode_fault), .sck_in(sck_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .mosi_in(mosi_in), .mosi_out(mosi_out),
    .mosi_oe(mosi_oe), .miso_in(miso_in), .miso_out(miso_out),
    .miso_oe(miso_oe), .ss_n(ss_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int run_len  = 0;
  int max_len  = 0;
  logic [7:0] done_rx = 8'h00;

  always @(negedge clk) begin
    if (done === 1'b1) begin
      run_len = run_len + 1;
      if (run_len == 1) begin
        done_cnt = done_cnt + 1;
        done_rx  = rx_byte;
      end
      if (run_len > max_len) max_len = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // master transfer against a behavioural slave
  task automatic run_master(input logic pl, input logic ph, input logic [1:0] rt,
                            input logic [7:0] mt, input logic [7:0] st);
    logic [7:0] stx, brx;
    logic       prev;
    int ec, t, last, half, base;
    bit gap_bad;
    en = 1; master = 1; wired_or = 0; cpol = pl; cpha = ph; rate = rt;
    ss_n = 1; ld = 0;
    repeat (4) step();
    chk(sck_out == pl, "R3 idle level before start", sck_out, pl);
    stx = st; brx = 8'h00; miso_in = stx[7];
    base = done_cnt; ec = 0; t = 0; last = 0; gap_bad = 0;
    half = 1 << (2 * rt); prev = sck_out;
    tx_byte = mt; ld = 1;
    step();
    ld = 0;
    chk(mosi_out == mt[7], "R11 first bit before first edge", mosi_out, mt[7]);
    chk(sck_out == pl, "R11 no edge yet", sck_out, pl);
    for (int i = 0; i < 4000; i++) begin
      if (sck_out !== prev) begin
        ec = ec + 1;
        if (ec > 1 && (t - last) != half) gap_bad = 1;
        last = t;
        if (((ec % 2) == 1) == (ph == 1'b0)) brx = {brx[6:0], mosi_out};
        else if (!(ph && ec == 1)) stx = {stx[6:0], 1'b0};
        miso_in = stx[7];
      end
      prev = sck_out;
      if (done_cnt != base) break;
      step();
      t = t + 1;
    end
    chk(done_cnt == base + 1, "R1 one done per transfer", done_cnt - base, 1);
    chk(done_rx == st, "R1 received byte", done_rx, st);
    chk(brx == mt, "R1 sent byte", brx, mt);
    chk(ec == 16, "R4 edge count", ec, 16);
    chk(!gap_bad, "R2 half period", gap_bad, 0);
    repeat (3) step();
    chk(sck_out == pl, "R3 idle level after", sck_out, pl);
    chk(rx_byte == st, "R10 rx_byte held", rx_byte, st);
  endtask

  // bench acts as master for one byte; ss already low
  task automatic slave_byte(input logic ph, input logic [7:0] mt, output logic [7:0] srx);
    logic [7:0] msh;
    msh = mt; srx = 8'h00; mosi_in = msh[7];
    for (int e = 1; e <= 16; e++) begin
      sck_in = ~sck_in;
      if (((e % 2) == 1) == (ph == 1'b0)) srx = {srx[6:0], miso_out};
      else if (!(ph && e == 1)) begin
        msh = {msh[6:0], 1'b0};
        mosi_in = msh[7];
      end
      repeat (SH) step();
    end
  endtask

  task automatic run_slave(input logic pl, input logic ph,
                           input logic [7:0] mt, input logic [7:0] st);
    logic [7:0] srx;
    int base;
    en = 1; master = 0; wired_or = 0; cpol = pl; cpha = ph; rate = 2'b11;
    ss_n = 1; sck_in = pl; mosi_in = 0;
    repeat (4) step();
    chk(miso_oe == 0, "R12 miso released while deselected", miso_oe, 0);
    tx_byte = st; ld = 1;
    step();
    ld = 0;
    base = done_cnt;
    ss_n = 0;
    repeat (SH) step();
    chk(miso_oe == 1, "R12 miso driven while selected", miso_oe, 1);
    if (!ph) chk(miso_out == st[7], "R11 slave first bit before edge", miso_out, st[7]);
    slave_byte(ph, mt, srx);
    chk(done_cnt == base + 1, "R5 slave done", done_cnt - base, 1);
    chk(done_rx == mt, "R5 slave received byte (rate=3 has no effect, R2)", done_rx, mt);
    chk(srx == st, "R5 slave sent byte", srx, st);
    if (!ph) begin
      slave_byte(ph, ~mt, srx);
      chk(done_cnt == base + 1, "R6 extra edges ignored", done_cnt - base, 1);
      chk(rx_byte == mt, "R6 rx_byte unchanged", rx_byte, mt);
    end else begin
      tx_byte = ~st; ld = 1;
      step();
      ld = 0;
      slave_byte(ph, ~mt, srx);
      chk(done_cnt == base + 2, "R5 back-to-back byte done", done_cnt - base, 2);
      chk(done_rx == ~mt, "R5 back-to-back received", done_rx, ~mt);
      chk(srx == ~st, "R5 back-to-back sent", srx, ~st);
    end
    ss_n = 1;
    repeat (4) step();
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 3000 && done_cnt == base; i++) step();
  endtask

  task automatic tests();
    int base;
    logic [7:0] pat;
    rst_n = 0; en = 0; master = 0; cpol = 0; cpha = 0; rate = 0; wired_or = 0;
    ld = 0; tx_byte = 0; sck_in = 0; mosi_in = 0; miso_in = 0; ss_n = 1;
    repeat (5) step();
    rst_n = 1;
    repeat (4) step();
    chk(done == 0, "R10 done low after reset", done, 0);
    chk(rx_byte == 8'h00, "R10 rx_byte zero after reset", rx_byte, 0);
    chk(mode_fault == 0, "R7 no fault after reset", mode_fault, 0);

    // R9 disabled engine
    base = done_cnt; master = 1; tx_byte = 8'hC3; ld = 1;
    step();
    ld = 0;
    repeat (200) step();
    chk(done_cnt == base, "R9 load ignored when disabled", done_cnt - base, 0);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R9 enables low", {sck_oe, mosi_oe, miso_oe}, 0);
    master = 0; ss_n = 0;
    repeat (4) step();
    chk(miso_oe == 0, "R9 slave miso off when disabled", miso_oe, 0);
    ss_n = 1;
    repeat (4) step();

    // master sweep: every polarity, phase and rate
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 2; p++) begin
        pat = 8'(c * 37 + p * 91 + 8'h5A);
        run_master(c[0], c[1], c[3:2], pat, ~{pat[3:0], pat[7:4]});
      end
    end
    chk(max_len == 1, "R10 done one cycle wide", max_len, 1);

    // slave sweep
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        pat = 8'(c * 53 + p * 29 + 8'h96);
        run_slave(c[0], c[1], pat, {pat[0], pat[7:1]} ^ 8'h3C);
      end
    end
    chk(max_len == 1, "R10 slave done one cycle wide", max_len, 1);

    // R7 mode fault
    en = 1; master = 1; cpol = 0; cpha = 0; rate = 2'b11; ss_n = 1;
    repeat (4) step();
    base = done_cnt; tx_byte = 8'hA5; ld = 1;
    step();
    ld = 0;
    repeat (20) step();
    ss_n = 0;
    repeat (4) step();
    chk(mode_fault == 1, "R7 fault raised", mode_fault, 1);
    chk({sck_oe, mosi_oe} == 2'b00, "R7 outputs released", {sck_oe, mosi_oe}, 0);
    ld = 1;
    step();
    ld = 0;
    repeat (1500) step();
    chk(done_cnt == base, "R7 no done during fault", done_cnt - base, 0);
    ss_n = 1;
    repeat (4) step();
    chk(mode_fault == 0, "R7 fault clears", mode_fault, 0);
    run_master(1'b1, 1'b0, 2'b01, 8'h81, 8'h7E);

    // R8 open-drain outputs
    wired_or = 1; cpol = 1; rate = 2'b00;
    repeat (3) step();
    chk({sck_out, sck_oe} == 2'b00, "R8 sck high level released", {sck_out, sck_oe}, 0);
    cpol = 0;
    repeat (2) step();
    chk({sck_out, sck_oe} == 2'b01, "R8 sck low level driven", {sck_out, sck_oe}, 1);
    base = done_cnt; tx_byte = 8'h7F; ld = 1;
    step();
    ld = 0;
    chk({mosi_out, mosi_oe} == 2'b01, "R8 mosi zero driven", {mosi_out, mosi_oe}, 1);
    wait_done(base);
    base = done_cnt; tx_byte = 8'h80; ld = 1;
    step();
    ld = 0;
    chk({mosi_out, mosi_oe} == 2'b00, "R8 mosi one released", {mosi_out, mosi_oe}, 0);
    wait_done(base);
    master = 0; ss_n = 1;
    repeat (4) step();
    tx_byte = 8'h80; ld = 1;
    step();
    ld = 0; ss_n = 0;
    repeat (4) step();
    chk({miso_out, miso_oe} == 2'b00, "R8 miso one released", {miso_out, miso_oe}, 0);
    ss_n = 1; wired_or = 0;
    repeat (4) step();
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 0;
    fork
      tests();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule